// File: doc/BRIEF.md
# Instruction Fetch and Branch-Target Unit

This block owns the program counter of a simple 32-bit core and decides, every clock, which address is fetched next. A small word-addressed instruction store is read without a clock from the current program counter, and a dedicated incrementer produces the sequential successor address. Both the fetched word and the successor address are driven out to the rest of the datapath.

For a conditional branch, the caller presents a 16-bit offset, a branch-enable strobe and the result of an equality comparison made elsewhere. The unit sign-extends the offset and scales it by four so that it counts words. It adds the scaled offset to the successor address, not to the branch's own address. The branch is taken only when branch-enable and equality are both high. The select signal driven out uses inverted polarity: 0 means the target is loaded, and 1 means the sequential address is loaded. The instruction store is filled through a simple write port, word by word, before or during operation.

Top module: `ifetch_unit`

## Requirements
- R1: A synchronous active-high reset loads the program counter with 0x00000000 at the next rising edge, whatever the branch inputs are.
- R2: `instr` shows, without a clock, the stored word at index `pc[IDX_W+1:2]`, so the index wraps modulo 2^IDX_W words.
- R3: `pc_plus4` equals `pc + 4` at all times, wrapping modulo 2^32.
- R4: With `br_en` low, `regs_eq` and `br_off` have no effect: `sel_seq` is 1 and the next program counter is `pc + 4`.
- R5: With `br_en` and `regs_eq` both high, `sel_seq` is 0 and the next program counter is `pc + 4 + (sign_extend(br_off) << 2)`.
- R6: With `br_en` high and `regs_eq` low, `sel_seq` is 1 and the next program counter is `pc + 4`.
- R7: Bit 15 of `br_off` is the sign, so 0xFFFF branches back one word relative to `pc + 4`, 0x8000 gives the most negative displacement (-0x20000 bytes), and 0x7FFF gives the most positive (+0x1FFFC bytes).
- R8: When `ld_we` is high at a rising edge, `ld_word` is stored at index `ld_idx`. From then on it is visible on `instr` whenever the program counter selects that index.
- R9: Target and successor arithmetic wrap modulo 2^32, so a backward branch from address 0 can reach 0xFFFFFFFC, whose successor is 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_we | input | 1 | Write strobe for the instruction store |
| ld_idx | input | IDX_W | Word index written by the load port |
| ld_word | input | 32 | Word written by the load port |
| br_en | input | 1 | Current instruction is a conditional branch |
| regs_eq | input | 1 | The two compared register values are equal |
| br_off | input | OFF_W | Signed word offset of the branch |
| pc | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Sequential successor address |
| instr | output | 32 | Word fetched at the current program counter |
| sel_seq | output | 1 | Next-address select: 0 takes the target, 1 takes pc+4 |

## Verification
The only state is the program counter and the instruction store. A wrong program counter appears on `pc`, on `pc_plus4` and on `instr` in the same cycle it is registered, which is one edge after the inputs that caused it. A wrong offset extension or scaling shows up only on taken branches, so the stimulus covers positive, negative, zero, extreme and self-looping offsets. Inverted select polarity is visible on `sel_seq` before the edge. A wrong store index or write shows as a mismatched `instr` the first time the program counter reaches that word.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

    localparam int unsigned XLEN  = 32;
    localparam int unsigned STEP  = 4;
    localparam int unsigned SCALE = 2;

    typedef logic [XLEN-1:0] word_t;

    typedef struct packed {
        word_t pc;
    } ifu_state_t;

endpackage

// File: rtl/ifu_incr.sv
module ifu_incr
    import ifu_pkg::*;
(
    input  word_t cur_addr,
    output word_t seq_addr
);

    localparam word_t STEP_W = word_t'(STEP);

    always_comb begin
        seq_addr = cur_addr + STEP_W;
    end

endmodule

// File: rtl/ifu_target.sv
module ifu_target
    import ifu_pkg::*;
#(
    parameter int unsigned OFF_W = 16
) (
    input  word_t            base_addr,
    input  logic [OFF_W-1:0] off,
    output word_t            tgt_addr
);

    localparam int unsigned EXT_W = XLEN - OFF_W - SCALE;

    word_t disp;

    // sign-extend the offset, then scale it from words to bytes
    generate
        if (EXT_W > 0) begin : g_ext
            always_comb disp = {{EXT_W{off[OFF_W-1]}}, off, {SCALE{1'b0}}};
        end else begin : g_trunc
            always_comb disp = word_t'({off, {SCALE{1'b0}}});
        end
    endgenerate

    always_comb begin
        tgt_addr = base_addr + disp;
    end

endmodule

// File: rtl/ifu_nextsel.sv
module ifu_nextsel
    import ifu_pkg::*;
(
    input  logic  br_en,
    input  logic  regs_eq,
    input  word_t seq_addr,
    input  word_t tgt_addr,
    output logic  sel_seq,
    output word_t next_addr
);

    logic taken_d;

    always_comb begin
        taken_d   = br_en & regs_eq;
        sel_seq   = ~taken_d;           // inverted: 0 selects the target
        next_addr = sel_seq ? seq_addr : tgt_addr;
    end

endmodule

// File: rtl/ifu_imem.sv
module ifu_imem
    import ifu_pkg::*;
#(
    parameter int unsigned IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  word_t            wr_word,
    input  logic [IDX_W-1:0] rd_idx,
    output word_t            rd_word
);

    localparam int unsigned DEPTH = 1 << IDX_W;

    word_t mem_q [DEPTH];
    word_t mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_idx] = wr_word;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= mem_d[i];
        end
    end

    always_comb begin
        rd_word = mem_q[rd_idx];
    end

    assert_load_visible_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem_q[$past(wr_idx)] == $past(wr_word)));

endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit
    import ifu_pkg::*;
#(
    parameter int unsigned IDX_W    = 6,
    parameter int unsigned OFF_W    = 16,
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_we,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [31:0]      ld_word,
    input  logic             br_en,
    input  logic             regs_eq,
    input  logic [OFF_W-1:0] br_off,
    output logic [31:0]      pc,
    output logic [31:0]      pc_plus4,
    output logic [31:0]      instr,
    output logic             sel_seq
);

    localparam int unsigned EXT_W = XLEN - OFF_W - SCALE;

    ifu_state_t st_d, st_q;
    word_t      seq_addr, tgt_addr, next_addr;

    ifu_incr u_incr (
        .cur_addr (st_q.pc),
        .seq_addr (seq_addr)
    );

    ifu_target #(.OFF_W(OFF_W)) u_target (
        .base_addr (seq_addr),
        .off       (br_off),
        .tgt_addr  (tgt_addr)
    );

    ifu_nextsel u_sel (
        .br_en     (br_en),
        .regs_eq   (regs_eq),
        .seq_addr  (seq_addr),
        .tgt_addr  (tgt_addr),
        .sel_seq   (sel_seq),
        .next_addr (next_addr)
    );

    ifu_imem #(.IDX_W(IDX_W)) u_imem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ld_we),
        .wr_idx  (ld_idx),
        .wr_word (ld_word),
        .rd_idx  (st_q.pc[IDX_W+1:2]),
        .rd_word (instr)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.pc = RESET_PC;
        end else begin
            st_d.pc = next_addr;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        pc       = st_q.pc;
        pc_plus4 = seq_addr;
    end

    // ---------------- assertions ----------------
    assert_reset_pc_R1: assert property (@(posedge clk)
        rst |=> (pc == RESET_PC));

    assert_incr_R3: assert property (@(posedge clk) disable iff (rst)
        pc_plus4 == pc + 32'd4);

    assert_no_branch_R4: assert property (@(posedge clk) disable iff (rst)
        !br_en |=> (pc == $past(pc) + 32'd4));

    assert_taken_R5: assert property (@(posedge clk) disable iff (rst)
        (br_en && regs_eq) |=>
            (pc == $past(pc) + 32'd4 + {{EXT_W{$past(br_off[OFF_W-1])}}, $past(br_off), 2'b00}));

    assert_not_taken_R6: assert property (@(posedge clk) disable iff (rst)
        (br_en && !regs_eq) |=> (pc == $past(pc_plus4)));

    assert_sel_polarity_R5: assert property (@(posedge clk) disable iff (rst)
        (pc_plus4 != tgt_addr) |-> (sel_seq == (pc_plus4 == next_addr)));

    assert_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00);

endmodule

// File: tb/ifetch_unit_tb_top.sv
`timescale 1ns/100ps
module ifetch_unit_tb_top;

    localparam int unsigned IDX_W = 6;
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ld_we = 1'b0;
    logic [IDX_W-1:0]  ld_idx = '0;
    logic [31:0]       ld_word = '0;
    logic              br_en = 1'b0;
    logic              regs_eq = 1'b0;
    logic [15:0]       br_off = '0;
    logic [31:0]       pc, pc_plus4, instr;
    logic              sel_seq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ifetch_unit #(.IDX_W(IDX_W)) dut_i (
        .clk, .rst, .ld_we, .ld_idx, .ld_word,
        .br_en, .regs_eq, .br_off,
        .pc, .pc_plus4, .instr, .sel_seq
    );

    typedef struct packed {
        logic        en;
        logic        eq;
        logic [15:0] off;
        logic        sel;
        logic [31:0] nxt;
    } vec_t;

    // walked from pc = 0 right after reset
    localparam vec_t VECS [12] = '{
        '{1'b0, 1'b0, 16'h0000, 1'b1, 32'h0000_0004},  // R4
        '{1'b0, 1'b1, 16'h0010, 1'b1, 32'h0000_0008},  // R4 eq ignored
        '{1'b1, 1'b0, 16'h0010, 1'b1, 32'h0000_000C},  // R6
        '{1'b1, 1'b1, 16'h0003, 1'b0, 32'h0000_001C},  // R5 forward
        '{1'b1, 1'b1, 16'hFFFE, 1'b0, 32'h0000_0018},  // R7 backward
        '{1'b0, 1'b0, 16'h0000, 1'b1, 32'h0000_001C},  // R4
        '{1'b1, 1'b1, 16'h0000, 1'b0, 32'h0000_0020},  // R5 zero offset
        '{1'b1, 1'b1, 16'hFFFF, 1'b0, 32'h0000_0020},  // R7 self loop
        '{1'b1, 1'b0, 16'hFFFF, 1'b1, 32'h0000_0024},  // R6
        '{1'b1, 1'b1, 16'h7FFF, 1'b0, 32'h0002_0024},  // R7 max positive
        '{1'b1, 1'b1, 16'h8000, 1'b0, 32'h0000_0028},  // R7 max negative
        '{1'b0, 1'b1, 16'h8000, 1'b1, 32'h0000_002C}   // R4
    };

    function automatic logic [31:0] pattern(input int unsigned i);
        return 32'h5A00_0000 ^ (i * 32'h0001_0203);
    endfunction

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return pattern((a >> 2) % DEPTH);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // fill the store while reset is held (R8)
        @(negedge clk);
        for (int i = 0; i < DEPTH; i++) begin
            ld_we   = 1'b1;
            ld_idx  = IDX_W'(i);
            ld_word = pattern(i);
            step();
        end
        ld_we = 1'b0;
        br_en = 1'b1; regs_eq = 1'b1; br_off = 16'h0040;
        step();
        // reset state: R1, R2, R3
        check("R1 reset pc", pc, 32'h0);
        check("R2 instr at reset", instr, pattern(0));
        check("R3 pc_plus4 at reset", pc_plus4, 32'h4);
        rst = 1'b0;

        for (int v = 0; v < 12; v++) begin
            br_en = VECS[v].en; regs_eq = VECS[v].eq; br_off = VECS[v].off;
            #1;
            check($sformatf("R5/R6 sel vec%0d", v), 32'(sel_seq), 32'(VECS[v].sel));
            check($sformatf("R3 pc_plus4 vec%0d", v), pc_plus4, pc + 32'd4);
            step();
            check($sformatf("R4/R5/R6/R7 next pc vec%0d", v), pc, VECS[v].nxt);
            check($sformatf("R2 instr vec%0d", v), instr, word_at(VECS[v].nxt));
        end

        // R1: reset wins over a taken branch
        rst = 1'b1; br_en = 1'b1; regs_eq = 1'b1; br_off = 16'h0100;
        step();
        check("R1 reset over branch", pc, 32'h0);
        rst = 1'b0;

        // R9: backward branch from address 0 wraps, then the successor wraps
        br_off = 16'hFFFE;
        step();
        check("R9 wrap target", pc, 32'hFFFF_FFFC);
        check("R9 wrap successor", pc_plus4, 32'h0);
        check("R2 index wraps", instr, pattern(DEPTH - 1));
        br_en = 1'b0; regs_eq = 1'b0;
        step();
        check("R9 wrap to zero", pc, 32'h0);

        // R8: rewrite word 1 while running, then fetch it
        ld_we = 1'b1; ld_idx = IDX_W'(1); ld_word = 32'hDEAD_BEEF;
        step();
        ld_we = 1'b0;
        check("R8 reloaded word", instr, 32'hDEAD_BEEF);
        check("R8 pc after load", pc, 32'h4);
        step();
        check("R2 untouched neighbour", instr, pattern(2));

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule